// File: doc/BRIEF.md
# Target-Side Transmit Byte Queue with Event Flush and Lock

This block holds the bytes that an I2C target sends back to a controller during a read. Firmware pushes bytes through a write port. The bus-side shifter pops them through a show-ahead read port. Three event strobes from the protocol engine drive an automatic policy: own-address match, general-call match, and a NACK that closes a target read. Depending on configuration, each of these events can empty the queue, and the two match events can also lock the queue against firmware writes.

The lock is a two-state machine:
- **LK_OPEN**: firmware writes are accepted.
- **LK_HELD**: firmware writes are dropped.

Transitions:
- **OPEN→HELD** happens on a lock request, which is a match event in target mode with preload off.
- **HELD→OPEN** happens when firmware writes 1 to the flag-clear input and no new lock request arrives in the same cycle.
- Every other case stays in the current state.

The lock flag output is this state, so it acts as both the lock status and the interrupt flag. In preload mode firmware can stage data before a match. In that mode the ready signal seen by the shifter follows a firmware-driven bit.

Top module: `txq_target_tx`

## Requirements
- R1: After reset `tx_count` is 0 and `lock_flag` is 0.
- R2: Bytes leave `bus_data` in the order they were written. `tx_count` rises by one per accepted push and falls by one per accepted pop, and it is at most 8. A push while full is dropped. A pop while empty leaves the count at 0.
- R3: With `target_mode`=1 and `preload_mode`=0, an own-address or general-call strobe sets `lock_flag` on the next cycle.
- R4: With `preload_mode`=1, match strobes never set `lock_flag`. Bytes survive a match whose flush is disabled.
- R5: `tx_ready` equals `fw_tx_ready` when `preload_mode`=1. Otherwise it is 1 exactly when `tx_count` is non-zero.
- R6: In target mode an own-address strobe empties the queue (count 0 next cycle), unless `keep_on_addr`=1.
- R7: In target mode a general-call strobe empties the queue, unless `keep_on_gcall`=1.
- R8: In target mode a NACK strobe empties the queue, unless `keep_on_nack`=1. A NACK never sets the lock.
- R9: With `target_mode`=0 all three strobes have no effect on count or lock.
- R10: While `lock_flag`=1, firmware pushes are dropped and the count does not change. Pops still work.
- R11: `fw_flag_clr`=1 clears `lock_flag` on the next cycle, unless a lock request arrives in the same cycle, in which case the flag stays set.
- R12: When a flush coincides with a push or pop, the flush wins and the count is 0 next cycle.
- R13: With preload off, a match strobe sets `lock_flag` even when that match's flush is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| target_mode | input | 1 | 1 = target mode, 0 = master mode (policy off) |
| preload_mode | input | 1 | Suppresses the lock on matches |
| fw_tx_ready | input | 1 | Firmware ready bit used in preload mode |
| keep_on_addr | input | 1 | Disables flush on own-address match |
| keep_on_gcall | input | 1 | Disables flush on general-call match |
| keep_on_nack | input | 1 | Disables flush on closing NACK |
| evt_addr | input | 1 | Own-address match strobe |
| evt_gcall | input | 1 | General-call match strobe |
| evt_nack | input | 1 | Closing NACK strobe |
| fw_wr_en | input | 1 | Firmware push |
| fw_wr_data | input | 8 | Byte to push |
| fw_flag_clr | input | 1 | Write-1 clear of the lock flag |
| bus_pop | input | 1 | Shifter pop |
| bus_data | output | 8 | Head byte (show-ahead) |
| tx_count | output | 4 | Bytes held, 0 to 8 |
| tx_ready | output | 1 | Data-ready signal toward the shifter |
| lock_flag | output | 1 | Lock state and interrupt flag |

## Verification
The bench covers the following cases:
- **Flush disabled but lock still expected.** A design that tied the lock to the flush would leave the flag low here.
- **Clear arriving in the same cycle as a fresh match.** A design that gave priority to the clear would lose the event.
- **Push colliding with a flush.** A design where the push won would report a count of 1 instead of 0.
- **Writes while locked.** A design that did not drop them would see its count grow.
- **Master mode.** Every strobe must be ignored there.
- **Full and empty edges.** A push at 8 entries and a pop at 0 entries would expose counter wrap.
- **Preload ready source.** With an empty queue, `tx_ready` must still follow the firmware bit.

// File: rtl/txq_pkg.sv
package txq_pkg;
    typedef enum logic [0:0] {
        LK_OPEN = 1'b0,
        LK_HELD = 1'b1
    } lock_state_e;

    localparam int EV_N    = 3;
    localparam int EV_OWN  = 0;
    localparam int EV_GEN  = 1;
    localparam int EV_NACK = 2;
endpackage

// File: rtl/txq_policy.sv
module txq_policy
    import txq_pkg::*;
(
    input  logic            target_mode,
    input  logic            preload_mode,
    input  logic [EV_N-1:0] evt,
    input  logic [EV_N-1:0] keep,
    output logic            flush,
    output logic            lock_req
);
    logic [EV_N-1:0] drop_v;

    // one flush qualifier per bus event
    for (genvar g = 0; g < EV_N; g++) begin : g_drop
        assign drop_v[g] = target_mode & evt[g] & ~keep[g];
    end

    assign flush    = |drop_v;
    // lock is independent of the per-event keep bits; only preload masks it
    assign lock_req = target_mode & ~preload_mode & (evt[EV_OWN] | evt[EV_GEN]);
endmodule

// File: rtl/txq_lock_fsm.sv
module txq_lock_fsm
    import txq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lock_req,
    input  logic clr_req,
    output logic locked
);
    lock_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN: if (lock_req) state_d = LK_HELD;
            LK_HELD: if (clr_req && !lock_req) state_d = LK_OPEN;
            default: state_d = LK_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        locked = (state_q == LK_HELD);
    end
endmodule

// File: rtl/txq_store.sv
module txq_store #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head_data,
    output logic [CNT_W-1:0] count
);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    assign push_ok   = push && (count != FULL_CNT);
    assign pop_ok    = pop && (count != '0);
    assign head_data = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            if (push_ok && !pop_ok)      count <= count + CNT_W'(1);
            else if (pop_ok && !push_ok) count <= count - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push_ok && !flush) begin
            mem[wr_ptr] <= push_data;
        end
    end
endmodule

// File: rtl/txq_target_tx.sv
module txq_target_tx
    import txq_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             target_mode,
    input  logic             preload_mode,
    input  logic             fw_tx_ready,
    input  logic             keep_on_addr,
    input  logic             keep_on_gcall,
    input  logic             keep_on_nack,
    input  logic             evt_addr,
    input  logic             evt_gcall,
    input  logic             evt_nack,
    input  logic             fw_wr_en,
    input  logic [WIDTH-1:0] fw_wr_data,
    input  logic             fw_flag_clr,
    input  logic             bus_pop,
    output logic [WIDTH-1:0] bus_data,
    output logic [CNT_W-1:0] tx_count,
    output logic             tx_ready,
    output logic             lock_flag
);
    logic [EV_N-1:0] evt_v, keep_v;
    logic            flush, lock_req, locked;

    always_comb begin
        evt_v           = '0;
        keep_v          = '0;
        evt_v[EV_OWN]   = evt_addr;
        evt_v[EV_GEN]   = evt_gcall;
        evt_v[EV_NACK]  = evt_nack;
        keep_v[EV_OWN]  = keep_on_addr;
        keep_v[EV_GEN]  = keep_on_gcall;
        keep_v[EV_NACK] = keep_on_nack;
    end

    txq_policy u_policy (
        .target_mode (target_mode),
        .preload_mode(preload_mode),
        .evt         (evt_v),
        .keep        (keep_v),
        .flush       (flush),
        .lock_req    (lock_req)
    );

    txq_lock_fsm u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .lock_req(lock_req),
        .clr_req (fw_flag_clr),
        .locked  (locked)
    );

    txq_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .push     (fw_wr_en && !locked),
        .push_data(fw_wr_data),
        .pop      (bus_pop),
        .head_data(bus_data),
        .count    (tx_count)
    );

    always_comb begin
        lock_flag = locked;
        tx_ready  = preload_mode ? fw_tx_ready : (tx_count != '0);
    end
endmodule

// File: rtl/txq_chk.sv
module txq_chk #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             target_mode,
    input logic             preload_mode,
    input logic             keep_on_addr,
    input logic             keep_on_gcall,
    input logic             keep_on_nack,
    input logic             evt_addr,
    input logic             evt_gcall,
    input logic             evt_nack,
    input logic             fw_wr_en,
    input logic             fw_flag_clr,
    input logic             bus_pop,
    input logic [CNT_W-1:0] tx_count,
    input logic             lock_flag
);
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tx_count <= CNT_W'(DEPTH));

    a_r3_match_locks: assert property (@(posedge clk) disable iff (!rst_n)
        target_mode && !preload_mode && (evt_addr || evt_gcall) |=> lock_flag);

    a_r4_preload_no_lock: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_flag && preload_mode |=> !lock_flag);

    a_r6_addr_flush: assert property (@(posedge clk) disable iff (!rst_n)
        target_mode && evt_addr && !keep_on_addr |=> tx_count == '0);

    a_r7_gcall_flush: assert property (@(posedge clk) disable iff (!rst_n)
        target_mode && evt_gcall && !keep_on_gcall |=> tx_count == '0);

    a_r8_nack_flush: assert property (@(posedge clk) disable iff (!rst_n)
        target_mode && evt_nack && !keep_on_nack |=> tx_count == '0);

    a_r9_master_no_lock: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_flag && !target_mode |=> !lock_flag);

    a_r9_master_no_flush: assert property (@(posedge clk) disable iff (!rst_n)
        !target_mode && !fw_wr_en && !bus_pop |=> tx_count == $past(tx_count));

    a_r10_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        lock_flag && !bus_pop && !evt_addr && !evt_gcall && !evt_nack
        |=> tx_count == $past(tx_count));

    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        lock_flag && fw_flag_clr
        && !(target_mode && !preload_mode && (evt_addr || evt_gcall))
        |=> !lock_flag);
endmodule

bind txq_target_tx txq_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .target_mode  (target_mode),
    .preload_mode (preload_mode),
    .keep_on_addr (keep_on_addr),
    .keep_on_gcall(keep_on_gcall),
    .keep_on_nack (keep_on_nack),
    .evt_addr     (evt_addr),
    .evt_gcall    (evt_gcall),
    .evt_nack     (evt_nack),
    .fw_wr_en     (fw_wr_en),
    .fw_flag_clr  (fw_flag_clr),
    .bus_pop      (bus_pop),
    .tx_count     (tx_count),
    .lock_flag    (lock_flag)
);

// File: tb/sim_txq_target_tx.sv
module sim_txq_target_tx;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic       tgt, pre, ka, kg, kn, ea, eg, en, wr, rd, clr;
        logic [7:0] wd;
        logic [3:0] ecnt;
        logic       elk;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{1,0,0,0,0,0,0,0,1,0,0,8'hA1,1,0,2},  // R2 push
        '{1,0,0,0,0,0,0,0,1,0,0,8'hA2,2,0,2},
        '{1,0,0,0,0,0,0,0,1,0,0,8'hA3,3,0,2},
        '{1,0,0,0,0,0,0,0,0,1,0,8'h00,2,0,2},  // R2 pop
        '{1,0,0,0,0,1,0,0,0,0,0,8'h00,0,1,3},  // R3 lock + R6 flush
        '{1,0,0,0,0,0,0,0,1,0,0,8'hB1,0,1,10}, // R10 write dropped
        '{1,0,0,0,0,0,0,0,0,0,1,8'h00,0,0,11}, // R11 clear
        '{1,0,0,0,0,0,0,0,1,0,0,8'h11,1,0,2},
        '{1,0,0,0,0,0,0,0,1,0,0,8'h12,2,0,2},
        '{1,0,0,1,0,0,1,0,0,0,0,8'h00,2,1,13}, // R13 lock w/o flush, R7 keep
        '{1,0,0,0,0,0,0,0,0,0,1,8'h00,2,0,11},
        '{1,0,0,0,1,0,0,1,0,0,0,8'h00,2,0,8},  // R8 keep on nack
        '{1,0,0,0,0,0,0,1,0,0,0,8'h00,0,0,8},  // R8 nack flush
        '{1,0,0,0,0,0,0,0,1,0,0,8'h21,1,0,2},
        '{1,1,1,0,0,1,0,0,0,0,0,8'h00,1,0,4},  // R4 preload keeps data
        '{1,1,0,0,0,0,1,0,0,0,0,8'h00,0,0,7},  // R4 + R7 flush
        '{1,0,0,0,0,0,0,0,1,0,0,8'h31,1,0,2},
        '{0,0,0,0,0,1,1,1,0,0,0,8'h00,1,0,9},  // R9 master ignores all
        '{1,0,0,0,0,1,0,0,1,0,0,8'h32,0,1,12}, // R12 flush beats push
        '{1,0,0,1,0,0,1,0,0,0,1,8'h00,0,1,11}, // R11 set wins over clear
        '{1,0,0,0,0,0,0,0,0,0,1,8'h00,0,0,11}
    };

    logic       clk = 0, rst_n = 0;
    logic       target_mode = 1, preload_mode = 0, fw_tx_ready = 0;
    logic       keep_on_addr = 0, keep_on_gcall = 0, keep_on_nack = 0;
    logic       evt_addr = 0, evt_gcall = 0, evt_nack = 0;
    logic       fw_wr_en = 0, fw_flag_clr = 0, bus_pop = 0;
    logic [7:0] fw_wr_data = 0, bus_data;
    logic [3:0] tx_count;
    logic       tx_ready, lock_flag;
    int         n_run = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txq_target_tx u0 (.*);

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle();
        evt_addr = 0; evt_gcall = 0; evt_nack = 0;
        fw_wr_en = 0; fw_flag_clr = 0; bus_pop = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R1", "count after reset", tx_count, 0);
        chk("R1", "lock after reset", lock_flag, 0);

        for (int i = 0; i < NV; i++) begin
            target_mode = VEC[i].tgt; preload_mode = VEC[i].pre;
            keep_on_addr = VEC[i].ka; keep_on_gcall = VEC[i].kg; keep_on_nack = VEC[i].kn;
            evt_addr = VEC[i].ea; evt_gcall = VEC[i].eg; evt_nack = VEC[i].en;
            fw_wr_en = VEC[i].wr; bus_pop = VEC[i].rd; fw_flag_clr = VEC[i].clr;
            fw_wr_data = VEC[i].wd;
            tick();
            idle();
            if (tx_count != VEC[i].ecnt || lock_flag != VEC[i].elk) begin
                n_fail++;
                $display("FAIL R%0d vector %0d: actual cnt=%0d lock=%0d expected cnt=%0d lock=%0d",
                         VEC[i].req, i, tx_count, lock_flag, VEC[i].ecnt, VEC[i].elk);
            end
            n_run++;
        end

        // R2: fill past full
        target_mode = 1; preload_mode = 0;
        keep_on_addr = 0; keep_on_gcall = 0; keep_on_nack = 0;
        for (int i = 0; i < 9; i++) begin
            fw_wr_en = 1; fw_wr_data = 8'h40 + 8'(i);
            tick();
        end
        idle();
        chk("R2", "count at full", tx_count, 8);
        chk("R5", "ready with data", tx_ready, 1);
        // R2: order
        for (int i = 0; i < 8; i++) begin
            chk("R2", "head byte", bus_data, 8'h40 + i);
            bus_pop = 1;
            tick();
            idle();
        end
        chk("R2", "count drained", tx_count, 0);
        chk("R5", "ready empty", tx_ready, 0);
        bus_pop = 1;
        tick();
        idle();
        chk("R2", "pop empty", tx_count, 0);

        // R5: preload ready source
        preload_mode = 1; fw_tx_ready = 1;
        #1;
        chk("R5", "preload ready high", tx_ready, 1);
        fw_tx_ready = 0;
        fw_wr_en = 1; fw_wr_data = 8'h77;
        tick();
        idle();
        chk("R5", "preload ready low", tx_ready, 0);
        preload_mode = 0;

        // R10: pop still works while locked
        evt_addr = 1; keep_on_addr = 1;
        tick();
        idle();
        chk("R10", "locked keeps data", tx_count, 1);
        bus_pop = 1;
        tick();
        idle();
        chk("R10", "pop while locked", tx_count, 0);

        // R1: reset mid-operation
        fw_flag_clr = 1;
        tick();
        idle();
        fw_wr_en = 1; fw_wr_data = 8'h55;
        tick();
        idle();
        evt_addr = 1;
        tick();
        idle();
        rst_n = 0;
        tick();
        rst_n = 1;
        chk("R1", "count after re-reset", tx_count, 0);
        chk("R1", "lock after re-reset", lock_flag, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule